// File: doc/BRIEF.md
# Alternating Dual-Kernel Sequencer

This block controls an outer loop that starts two loop kernels in turn. It holds a one-bit lane selector and an outer iteration counter. A pulse on `run_req` sets the selector to the first lane and the counter to zero. On each outer iteration the loop head tests the counter, and the dispatch stage sends a one-cycle start pulse to the kernel that the selector names. The block then waits for that kernel's completion pulse. The loop tail flips the selector, increments the counter and passes control back to the head. When the counter reaches its limit, an exit stage raises `all_done` and holds it there.

Control does not run through one encoded state register. It moves as one-bit predicators that are registered from node to node (entry, head, dispatch, tail, exit), so each node acts one cycle after the node that fed it. The head combines the entry predicator and the tail predicator with an OR. The kernels sit outside the block. They may take any number of cycles, and each reports completion with a single-cycle pulse.

Top module: `alt_kernel_seq`

## Requirements
- R1: After reset, `kick_first`, `kick_second` and `all_done` are all low, and stay low until `run_req` is pulsed.
- R2: A `run_req` pulse sampled at clock edge E produces the first kernel start on `kick_first` (selector initial value 1 = first lane), visible after edge E+2.
- R3: Successive outer iterations start the kernels strictly in turn: first, second, first, second, and so on.
- R4: One `run_req` gives exactly ITER_COUNT (default 10) kernel starts, and no start is issued while `all_done` is high.
- R5: Every kernel start is a single-cycle pulse, the two start outputs are never high together, and no further start is issued until the running kernel reports completion.
- R6: A completion pulse from the running kernel, sampled at edge D, produces the next kernel start after edge D+2.
- R7: A completion pulse from the kernel that is not running, or any completion pulse while no kernel runs, has no effect.
- R8: The completion of the last run, sampled at edge D, raises `all_done` after edge D+2. `all_done` then stays high until the next `run_req` and falls after the edge that samples that request.
- R9: A `run_req` during a run discards the run in progress, resets the selector and the counter, and starts a complete new sequence of ITER_COUNT runs on the first lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_req | input | 1 | Start request; starts or restarts the outer loop |
| fin_first | input | 1 | Completion pulse from the first kernel |
| fin_second | input | 1 | Completion pulse from the second kernel |
| kick_first | output | 1 | Start pulse to the first kernel |
| kick_second | output | 1 | Start pulse to the second kernel |
| all_done | output | 1 | High once the outer loop has completed, until the next request |

## Verification
The bench acts as both kernels. It answers each start after a random delay taken from a fixed seed, and it counts edges from every trigger to the next start. This separates correct forwarding latency from off-by-one staging. In some runs the bench pulses the completion input of the idle kernel while the other kernel runs, and it also pulses both completion inputs after the loop has finished. A block that accepts the wrong completion breaks the expected lane order or the count. Directed cases cover a restart in the middle of a sequence and a restart after completion, which show whether the selector and the counter are truly set back to their start values.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Lane selector values; the selector value 1 names the first kernel.
  typedef enum logic {
    LANE_SECOND = 1'b0,
    LANE_FIRST  = 1'b1
  } lane_sel_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/seq_loop_head.sv
// Entry node, loop head (OR of predicators plus bound test) and exit node.
module seq_loop_head #(
  parameter int unsigned ITER_COUNT = 10,
  parameter int unsigned CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             p_tail_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             p_go_o,
  output logic             all_done_o
);
  logic p_entry_q, p_entry_d;
  logic p_go_q,    p_go_d;
  logic p_exit_q,  p_exit_d;
  logic done_q,    done_d;
  logic p_head;
  logic more_iter;

  always_comb begin
    p_head    = p_entry_q | p_tail_i;
    more_iter = (cnt_i < CNT_W'(ITER_COUNT));
    p_entry_d = run_req;
    p_go_d    = !run_req && p_head &&  more_iter;
    p_exit_d  = !run_req && p_head && !more_iter;
    done_d    = done_q;
    if (run_req)       done_d = 1'b0;
    else if (p_exit_q) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_entry_q <= 1'b0;
      p_go_q    <= 1'b0;
      p_exit_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      p_entry_q <= p_entry_d;
      p_go_q    <= p_go_d;
      p_exit_q  <= p_exit_d;
      done_q    <= done_d;
    end
  end

  assign p_go_o     = p_go_q;
  assign all_done_o = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !run_req) |=> done_q); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    run_req |=> !done_q); // R8
endmodule

// File: rtl/seq_dispatch.sv
// Dispatch node: issues the start pulse to the selected lane and tracks the run.
module seq_dispatch
  import seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_req,
  input  logic                 p_go_i,
  input  lane_sel_e            sel_i,
  input  logic [NUM_LANES-1:0] kdone_i,
  output logic [NUM_LANES-1:0] kick_o,
  output logic                 tail_fire_o
);
  logic [NUM_LANES-1:0] lane_hit;
  logic [NUM_LANES-1:0] kick_q, kick_d;
  logic                 busy_q, busy_d;
  logic                 done_pick;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lane_hit[g] = (sel_i == LANE_FIRST);
    end else begin : g_second
      assign lane_hit[g] = (sel_i == LANE_SECOND);
    end
    assign kick_d[g] = !run_req && p_go_i && lane_hit[g];
  end

  always_comb begin
    done_pick   = |(kdone_i & lane_hit);
    tail_fire_o = busy_q && done_pick && !run_req;
    busy_d      = busy_q;
    if (run_req)          busy_d = 1'b0;
    else if (p_go_i)      busy_d = 1'b1;
    else if (tail_fire_o) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_q <= '0;
      busy_q <= 1'b0;
    end else begin
      kick_q <= kick_d;
      busy_q <= busy_d;
    end
  end

  assign kick_o = kick_q;

  AST_ONE_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kick_q)); // R5
  AST_KICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q != '0) |=> (kick_q == '0)); // R5
endmodule

// File: rtl/seq_tail.sv
// Loop tail: holds selector and counter, fires on the running kernel's completion.
module seq_tail
  import seq_pkg::*;
#(
  parameter int unsigned ITER_COUNT = 10,
  parameter int unsigned CNT_W      = 4,
  parameter lane_sel_e   FLAG_INIT  = LANE_FIRST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             tail_fire_i,
  output lane_sel_e        sel_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             p_tail_o
);
  lane_sel_e        sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             p_tail_q, p_tail_d;

  always_comb begin
    sel_d    = sel_q;
    cnt_d    = cnt_q;
    p_tail_d = 1'b0;
    if (run_req) begin
      sel_d = FLAG_INIT;
      cnt_d = '0;
    end else if (tail_fire_i) begin
      sel_d    = lane_sel_e'(sel_q ^ 1'b1);
      cnt_d    = cnt_q + CNT_W'(1);
      p_tail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= FLAG_INIT;
      cnt_q    <= '0;
      p_tail_q <= 1'b0;
    end else begin
      sel_q    <= sel_d;
      cnt_q    <= cnt_d;
      p_tail_q <= p_tail_d;
    end
  end

  assign sel_o    = sel_q;
  assign cnt_o    = cnt_q;
  assign p_tail_o = p_tail_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ITER_COUNT)); // R4
  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    p_tail_q |-> (sel_q != $past(sel_q))); // R3
endmodule

// File: rtl/alt_kernel_seq.sv
module alt_kernel_seq
  import seq_pkg::*;
#(
  parameter int unsigned ITER_COUNT = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter lane_sel_e   FLAG_INIT  = LANE_FIRST
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic fin_first,
  input  logic fin_second,
  output logic kick_first,
  output logic kick_second,
  output logic all_done
);
  localparam int unsigned CNT_W = $clog2(ITER_COUNT + 1);

  logic                 rst_n_s;
  logic                 p_go;
  logic                 p_tail;
  logic                 tail_fire;
  logic [CNT_W-1:0]     cnt;
  lane_sel_e            sel;
  logic [NUM_LANES-1:0] kick;
  logic [NUM_LANES-1:0] kdone;

  assign kdone = {fin_second, fin_first};

  seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  seq_loop_head #(.ITER_COUNT(ITER_COUNT), .CNT_W(CNT_W)) u_head (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .run_req    (run_req),
    .p_tail_i   (p_tail),
    .cnt_i      (cnt),
    .p_go_o     (p_go),
    .all_done_o (all_done)
  );

  seq_dispatch u_dispatch (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run_req     (run_req),
    .p_go_i      (p_go),
    .sel_i       (sel),
    .kdone_i     (kdone),
    .kick_o      (kick),
    .tail_fire_o (tail_fire)
  );

  seq_tail #(.ITER_COUNT(ITER_COUNT), .CNT_W(CNT_W), .FLAG_INIT(FLAG_INIT)) u_tail (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .run_req     (run_req),
    .tail_fire_i (tail_fire),
    .sel_o       (sel),
    .cnt_o       (cnt),
    .p_tail_o    (p_tail)
  );

  assign kick_first  = kick[0];
  assign kick_second = kick[1];

  AST_FIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    all_done |-> (kick == '0)); // R4
endmodule

// File: tb/alt_kernel_seq_bench.sv
module alt_kernel_seq_bench;
  localparam int ITER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_req = 1'b0;
  logic fin_first = 1'b0;
  logic fin_second = 1'b0;
  logic kick_first, kick_second, all_done;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  alt_kernel_seq u_alt_kernel_seq (
    .clk(clk), .rst_n(rst_n), .run_req(run_req),
    .fin_first(fin_first), .fin_second(fin_second),
    .kick_first(kick_first), .kick_second(kick_second), .all_done(all_done)
  );

  function automatic int exp_kicks(input int lane);
    return (lane == 0) ? 2'b01 : 2'b10;
  endfunction

  function automatic int exp_lane(input int iter);
    return iter % 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kicks();
    return {30'd0, kick_second, kick_first};
  endfunction

  // Called at the negedge where a trigger was driven; expects the start 3 negedges later.
  task automatic expect_kick(input int lane, input string req, input bit first);
    @(negedge clk);
    run_req = 0; fin_first = 0; fin_second = 0;
    if (first) check(all_done == 0, "R8", all_done, 0);
    check(kicks() == 0, "R6", kicks(), 0);
    @(negedge clk);
    check(kicks() == 0, "R6", kicks(), 0);
    @(negedge clk);
    check(kicks() == exp_kicks(lane), req, kicks(), exp_kicks(lane));
    check(all_done == 0, "R4", all_done, 0);
    @(negedge clk);
    check(kicks() == 0, "R5", kicks(), 0);
  endtask

  task automatic full_run(input bit spur, input int stop_after);
    run_req = 1;
    for (int it = 0; it < ITER; it++) begin
      int lane = exp_lane(it);
      int d;
      expect_kick(lane, (it == 0) ? "R2" : "R3", it == 0);
      if (it == stop_after) return;
      d = $urandom_range(5, 0);
      if (spur && d == 0) d = 1;
      for (int k = 0; k < d; k++) begin
        if (spur && k == 0) begin
          if (lane == 0) fin_second = 1; else fin_first = 1;
        end
        @(negedge clk);
        fin_first = 0; fin_second = 0;
        check(kicks() == 0, spur ? "R7" : "R5", kicks(), 0);
      end
      if (lane == 0) fin_first = 1; else fin_second = 1;
    end
    @(negedge clk);
    fin_first = 0; fin_second = 0;
    check(all_done == 0, "R8", all_done, 0);
    @(negedge clk);
    check(all_done == 0, "R8", all_done, 0);
    @(negedge clk);
    check(all_done == 1, "R8", all_done, 1);
    check(kicks() == 0, "R4", kicks(), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(all_done == 1 && kicks() == 0, "R8", {all_done, kicks()[1:0]}, 3'b100);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(kicks() == 0 && all_done == 0, "R1", {all_done, kicks()[1:0]}, 0);
    // R1: idle completions before any request do nothing
    fin_first = 1; fin_second = 1;
    @(negedge clk);
    fin_first = 0; fin_second = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(kicks() == 0 && all_done == 0, "R1", {all_done, kicks()[1:0]}, 0);
    end
    full_run(0, -1);
    // R7: completions while finished are ignored
    fin_first = 1; fin_second = 1;
    @(negedge clk);
    fin_first = 0; fin_second = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(all_done == 1 && kicks() == 0, "R7", {all_done, kicks()[1:0]}, 3'b100);
    end
    full_run(1, -1);
    // R9: abort after the fourth start, restart at once
    full_run(1, 3);
    repeat (2) @(negedge clk);
    full_run(0, -1);
    // R9: restart again mid-run, then a late completion from the aborted lane
    full_run(0, 4);
    fin_first = 1;
    run_req = 1;
    expect_kick(0, "R9", 1);
    @(negedge clk);
    check(kicks() == 0, "R9", kicks(), 0);
    fin_first = 1;
    expect_kick(1, "R9", 0);
    repeat (3) @(negedge clk);
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule